// File: doc/BRIEF.md
# Asynchronous serial transmitter with selectable parity

This block turns one byte at a time into an asynchronous serial frame on a single output line. A frame is a low start bit, the eight data bits with the least significant bit first, an optional parity bit, and one high stop bit. Between frames the line rests high. The timing of every bit comes from a baud-tick enable made by a divider outside the block. Each bit on the line lasts sixteen of these ticks.

A two-bit parity mode input sets the contents of the parity slot. It can make the count of ones even, make it odd, force the slot to zero, or remove the slot from the frame. Bytes enter through a valid/ready handshake. The data and the mode are captured when a byte is accepted, so later changes on those inputs only apply from the next frame. A busy flag stays high for the whole frame.

Top module: `uart_tx_parity`

## Requirements
- R1: After reset and between frames the serial line is high, ready is high and busy is low.
- R2: A byte is accepted on a rising clock edge where valid and ready are both high. From the next cycle the line carries the low start bit, busy is high and ready stays low until the frame ends.
- R3: Each bit of the frame lasts exactly 16 baud ticks. The line does not change in a cycle where no baud tick was present.
- R4: The eight data bits follow the start bit, least significant bit first.
- R5: With parity mode 01 (even), the parity bit is 1 when the data holds an odd number of ones and 0 otherwise, so the ones in data plus parity add up to an even number.
- R6: With parity mode 10 (odd), the parity bit is 0 when the data holds an odd number of ones and 1 otherwise, so the ones in data plus parity add up to an odd number.
- R7: With parity mode 11 (zero), the parity bit is 0 for any data.
- R8: With parity mode 00 (none), the frame has no parity slot, and the stop bit comes directly after the last data bit (10 bits in all).
- R9: The frame ends with a high stop bit. In the cycle after the 16th tick of the stop bit, busy is low and ready is high.
- R10: Data and parity mode are captured at acceptance. Changes on those inputs during a frame have no effect on that frame.
- R11: Baud ticks while idle, with valid low, start no frame and leave the line high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Byte offered for transmission |
| in_ready | output | 1 | Block can accept a byte |
| in_data | input | 8 | Byte to send |
| par_mode | input | 2 | Parity mode: 00 none, 01 even, 10 odd, 11 zero |
| baud_tick | input | 1 | One-cycle enable, 16 per bit time |
| tx_line | output | 1 | Serial output line, idles high |
| busy | output | 1 | High while a frame is on the line |

## Verification
The case hardest to reach from the ports is a mode or data change in the middle of a frame. It has to arrive while the block is already counting ticks inside a bit. The stimulus scrambles both inputs on every cycle of selected frames, while baud ticks arrive with random gaps, and then checks the line against the values captured at acceptance. A separate frame stops the ticks for a hundred cycles in the middle of a data bit to show that the line holds its value. Random bytes in all four modes are mixed with all-zero, all-one and single-bit patterns, and frames are sent back to back.

// File: rtl/sertx_pkg.sv
// Shared types for the serial transmitter.
// Assumes the parity-mode encoding is fixed by the external interface.
package sertx_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_ZERO = 2'b11
    } par_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } phase_e;

endpackage

// File: rtl/sertx_parity_gen.sv
// Parity slot generator: from a data word and a mode, gives the bit to send in
// the parity slot and whether the slot exists at all.
// Purely combinational; the caller captures the result at byte acceptance.
module sertx_parity_gen
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        mode,
    output logic              par_bit,
    output logic              has_slot
);

    logic ones_odd;

    // Reduce the data word to a single odd-ones flag.
    always_comb begin
        ones_odd = ^data;
    end

    // Pick the slot contents for the selected mode.
    always_comb begin
        has_slot = 1'b1;
        par_bit  = 1'b0;
        case (par_mode_e'(mode))
            PAR_EVEN: par_bit = ones_odd;
            PAR_ODD:  par_bit = ~ones_odd;
            PAR_ZERO: par_bit = 1'b0;
            default: begin
                par_bit  = 1'b0;
                has_slot = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sertx_bit_timer.sv
// Bit-period timer: counts baud ticks inside one bit and flags the tick that
// ends the bit. Held at zero while the frame is not running, so a new frame
// always starts with a full bit period.
module sertx_bit_timer #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic baud_tick,
    output logic bit_done
);

    localparam int CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

    logic [CW-1:0] tick_cnt;

    // Flag the last tick of the current bit.
    always_comb begin
        bit_done = run && baud_tick && (tick_cnt == LAST);
    end

    // Advance the tick count, wrapping at the end of each bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            tick_cnt <= '0;
        end else if (baud_tick) begin
            tick_cnt <= (tick_cnt == LAST) ? '0 : tick_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sertx_frame_seq.sv
// Frame sequencer: captures a byte and its parity decision at acceptance, then
// steps through the start, data, parity and stop phases, one per bit_done.
// Assumes bit_done is only asserted while busy.
module sertx_frame_seq
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_par_bit,
    input  logic              load_has_slot,
    input  logic              bit_done,
    output logic              ready,
    output logic              busy,
    output logic              line
);

    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IW-1:0] IDX_LAST = IW'(DATA_W - 1);

    phase_e            phase;
    logic [DATA_W-1:0] shreg;
    logic [IW-1:0]     bit_idx;
    logic              par_q;
    logic              slot_q;

    // Handshake and activity flags follow the phase register.
    always_comb begin
        ready = (phase == PH_IDLE);
        busy  = (phase != PH_IDLE);
    end

    // Serial line level for the current phase.
    always_comb begin
        case (phase)
            PH_START:  line = 1'b0;
            PH_DATA:   line = shreg[0];
            PH_PARITY: line = par_q;
            default:   line = 1'b1;
        endcase
    end

    // Phase stepping, byte capture and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            shreg   <= '0;
            bit_idx <= '0;
            par_q   <= 1'b0;
            slot_q  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        phase   <= PH_START;
                        shreg   <= load_data;
                        par_q   <= load_par_bit;
                        slot_q  <= load_has_slot;
                        bit_idx <= '0;
                    end
                end
                PH_START: begin
                    if (bit_done) phase <= PH_DATA;
                end
                PH_DATA: begin
                    if (bit_done) begin
                        shreg   <= shreg >> 1;
                        bit_idx <= bit_idx + 1'b1;
                        if (bit_idx == IDX_LAST) begin
                            phase <= slot_q ? PH_PARITY : PH_STOP;
                        end
                    end
                end
                PH_PARITY: begin
                    if (bit_done) phase <= PH_STOP;
                end
                PH_STOP: begin
                    if (bit_done) phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/uart_tx_parity.sv
// Asynchronous serial transmitter with four parity modes.
// Accepts a byte through valid/ready, then sends start, data (LSB first),
// optional parity and stop bits, each TICKS_PER_BIT baud ticks long.
// Assumes baud_tick is a one-cycle enable from an external divider.
module uart_tx_parity
    import sertx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [1:0]        par_mode,
    input  logic              baud_tick,
    output logic              tx_line,
    output logic              busy
);

    logic accept;
    logic par_bit;
    logic has_slot;
    logic bit_done;

    // Handshake completes when both sides agree in the same cycle.
    always_comb begin
        accept = in_valid && in_ready;
    end

    sertx_parity_gen #(
        .DATA_W(DATA_W)
    ) u_par (
        .data     (in_data),
        .mode     (par_mode),
        .par_bit  (par_bit),
        .has_slot (has_slot)
    );

    sertx_bit_timer #(
        .TICKS_PER_BIT(TICKS_PER_BIT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy),
        .baud_tick (baud_tick),
        .bit_done  (bit_done)
    );

    sertx_frame_seq #(
        .DATA_W(DATA_W)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .accept        (accept),
        .load_data     (in_data),
        .load_par_bit  (par_bit),
        .load_has_slot (has_slot),
        .bit_done      (bit_done),
        .ready         (in_ready),
        .busy          (busy),
        .line          (tx_line)
    );

endmodule

// File: rtl/uart_tx_parity_chk.sv
// Port-level protocol checks for the serial transmitter, bound to every instance.
module uart_tx_parity_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic baud_tick,
    input logic tx_line,
    input logic busy
);

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tx_line && in_ready));

    // R2
    accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (busy && !tx_line && !in_ready));

    // R3
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !baud_tick) |=> $stable(tx_line));

    // R9
    end_on_stop_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(baud_tick) && $past(tx_line)));

endmodule

bind uart_tx_parity uart_tx_parity_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .baud_tick (baud_tick),
    .tx_line   (tx_line),
    .busy      (busy)
);

// File: tb/tb_uart_tx_parity.sv
module tb_uart_tx_parity;

    localparam int CLK_PERIOD = 10;
    localparam int TPB        = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic [1:0] par_mode = 2'b00;
    logic       baud_tick = 1'b0;
    logic       tx_line;
    logic       busy;

    int total = 0;
    int bad = 0;
    bit scramble = 1'b0;
    int tick_pct = 100;

    uart_tx_parity dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .par_mode  (par_mode),
        .baud_tick (baud_tick),
        .tx_line   (tx_line),
        .busy      (busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected parity slot value, counted bit by bit.
    function automatic logic exp_parity(logic [7:0] d, logic [1:0] m);
        int ones = 0;
        for (int i = 0; i < 8; i++) ones += d[i];
        case (m)
            2'b01:   return (ones % 2) == 1;
            2'b10:   return (ones % 2) == 0;
            default: return 1'b0;
        endcase
    endfunction

    // One cycle: move to the falling edge, choose the tick, optionally scramble inputs.
    task automatic cyc();
        @(negedge clk);
        baud_tick = (($urandom % 100) < tick_pct);
        if (scramble && !in_valid) begin
            in_data  = 8'($urandom);
            par_mode = 2'($urandom);
        end
    endtask

    task automatic run_frame(logic [7:0] d, logic [1:0] m, bit stall, string tag);
        logic exp_bits [0:10];
        bit   bit_bad  [0:10];
        int   nb;
        int   b = 0;
        int   t = 0;
        bit   rdy_bad = 0;
        bit   stalled = 0;
        bit   stall_bad = 0;
        string rq;
        exp_bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) exp_bits[i+1] = d[i];
        if (m != 2'b00) begin
            exp_bits[9] = exp_parity(d, m);
            nb = 11;
        end else begin
            nb = 10;
        end
        exp_bits[nb-1] = 1'b1;
        for (int i = 0; i < 11; i++) bit_bad[i] = 0;
        // offer the byte
        cyc();
        in_valid = 1'b1;
        in_data  = d;
        par_mode = m;
        while (b < nb) begin
            cyc();
            in_valid = 1'b0;
            if (tx_line !== exp_bits[b]) bit_bad[b] = 1;
            if (in_ready !== 1'b0 || busy !== 1'b1) rdy_bad = 1;
            if (baud_tick) begin
                t++;
                if (t == TPB) begin
                    t = 0;
                    b++;
                end
            end
            if (stall && !stalled && b == 4 && t == 5) begin
                stalled = 1;
                for (int k = 0; k < 100; k++) begin
                    @(negedge clk);
                    baud_tick = 1'b0;
                    if (tx_line !== exp_bits[4]) stall_bad = 1;
                end
            end
        end
        cyc();
        check(in_ready === 1'b1 && busy === 1'b0 && tx_line === 1'b1, "R9",
              "idle after stop", {in_ready, busy, tx_line}, 3'b101);
        check(!rdy_bad, (tag != "") ? tag : "R2", "ready low/busy high in frame", rdy_bad, 0);
        if (stall) check(!stall_bad, "R3", "line held without ticks", stall_bad, 0);
        for (int i = 0; i < nb; i++) begin
            if (tag != "")            rq = tag;
            else if (i == 0)          rq = "R2";
            else if (i <= 8)          rq = "R4";
            else if (i == nb - 1)     rq = (m == 2'b00) ? "R8" : "R9";
            else if (m == 2'b01)      rq = "R5";
            else if (m == 2'b10)      rq = "R6";
            else                      rq = "R7";
            check(!bit_bad[i], rq, $sformatf("frame bit %0d of byte %0h mode %0d", i, d, m),
                  bit_bad[i], 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(tx_line === 1'b1 && in_ready === 1'b1 && busy === 1'b0, "R1",
              "reset state", {tx_line, in_ready, busy}, 3'b110);
        // R11 idle ticks do nothing
        begin
            bit idle_bad = 0;
            for (int k = 0; k < 60; k++) begin
                @(negedge clk);
                baud_tick = k[0];
                if (tx_line !== 1'b1 || busy !== 1'b0) idle_bad = 1;
            end
            check(!idle_bad, "R11", "idle with ticks", idle_bad, 0);
        end
        // directed corners, tick every cycle
        tick_pct = 100;
        for (int m = 0; m < 4; m++) begin
            run_frame(8'h00, 2'(m), 0, "");
            run_frame(8'hFF, 2'(m), 0, "");
            run_frame(8'h01, 2'(m), 0, "");
            run_frame(8'h80, 2'(m), 0, "");
        end
        // R3 stall mid data bit
        tick_pct = 60;
        run_frame(8'hA5, 2'b01, 1, "");
        // R10 inputs scrambled during frames
        scramble = 1'b1;
        for (int k = 0; k < 6; k++) run_frame(8'($urandom), 2'(k), 0, "R10");
        scramble = 1'b0;
        // random frames with random tick density
        for (int k = 0; k < 30; k++) begin
            tick_pct = 30 + int'($urandom % 71);
            run_frame(8'($urandom), 2'($urandom), 0, "");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule